// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit up-counter driven by one external input pin. It has two modes. In event mode it counts qualified edges of the pin. In gated mode it counts ticks of a free-running internal divide-by-64 timebase, but only while the pin is at its active level. In gated mode the count is therefore a measure of how long the gate was active, in units of 64 system clocks. One polarity bit picks the qualifying edge in event mode and the active gate level in gated mode.

The pin passes through a two-flop synchronizer before any edge or level is used. Software reaches the block through a small register port with three decoded addresses: control, counter and status. The status register holds two sticky flags, counter overflow and input edge. Writing 1 to a flag's bit clears it. Each flag drives its own interrupt request when its enable bit is set. A system clock-enable input freezes the synchronizer, the prescaler and all counting while it is low.

Top module: `pulse_accum`

## Requirements
- R1: After reset, every register reads 0x00 and both interrupt requests are low.
- R2: At address 0, bit 6 is count enable, bit 5 is mode (0 event, 1 gated), bit 4 is polarity, bit 1 is overflow-interrupt enable and bit 0 is edge-interrupt enable. Bits 7, 3 and 2 always read zero. Writing 0xFF therefore reads back 0x73.
- R3: In event mode, each rising pin edge (polarity 1) or falling pin edge (polarity 0) adds one to the counter at address 1. The count appears within four clocks of the pin change. This holds for a pin that toggles every clock.
- R4: In gated mode the counter advances once per 64 system clocks while the pin is active. Active means high for polarity 0 and low for polarity 1. A gate held active for 64·N clocks adds exactly N. An inactive pin adds nothing.
- R5: While the enable bit is clear, the counter does not change and neither status flag is set.
- R6: An increment from 0xFF to 0x00 sets the sticky overflow flag, which reads as status bit 7 at address 2.
- R7: The edge flag (status bit 6) is set by a qualified edge in event mode. In gated mode it is set by the trailing edge of the gate.
- R8: Writing address 2 clears each flag whose data bit (7 or 6) is 1. Flags whose data bit is 0 are left unchanged.
- R9: The overflow request is high exactly when the overflow flag and its enable are both set. The edge request follows the same rule with its own flag and enable.
- R10: Software may write the counter at any time. A write in the same cycle as an increment wins: the counter takes the written value, and no overflow is flagged for that cycle.
- R11: While the system clock-enable input is low, pin activity does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_en | input | 1 | System clock enable; freezes synchronizer, prescaler and counting when low |
| pin_in | input | 1 | External event or gate input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 status, 3 reads zero |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected address |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-edge interrupt request |

## Verification
Two actions can land on the counter in the same clock: a software write to address 1 and an increment caused by a synchronized pin edge. To force this, the bench raises the pin, waits for the two synchronizer stages, and times the write so it reaches the clock edge at which the increment would take effect. The counter is preloaded with 0xFF. A correct block then shows the written value, with no extra count and no overflow flag.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } pa_addr_e;

    // Control bit positions
    localparam int CB_EN     = 6;
    localparam int CB_MODE   = 5;
    localparam int CB_POL    = 4;
    localparam int CB_OVF_IE = 1;
    localparam int CB_EDG_IE = 0;

    // Status bit positions
    localparam int SB_OVF = 7;
    localparam int SB_EDG = 6;

    typedef struct packed {
        logic en;
        logic mode;
        logic pol;
        logic ovf_ie;
        logic edge_ie;
    } pa_ctrl_t;

endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (adv) sh_d = {sh_q[W-2:0], din};
        level = sh_q[STAGES-1];
        rise  = adv &  sh_q[STAGES-1] & ~sh_q[STAGES];
        fall  = adv & ~sh_q[STAGES-1] &  sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = adv && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (adv) cnt_d = tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRESCALE = 64,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_en,
    input  logic              pin_in,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_ovf,
    output logic              irq_edge
);
    typedef struct packed {
        pa_ctrl_t          ctrl;
        logic [DATA_W-1:0] cnt;
        logic              ovf;
        logic              edg;
    } pa_state_t;

    pa_state_t st_d, st_q;

    logic pin_lvl, pin_rise, pin_fall, tick;
    logic ctrl_wr, cnt_wr, stat_wr;
    logic qual_edge, gate_on, inc, ovf_set, edge_set;

    pa_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (sys_en),
        .din   (pin_in),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    pa_prescale #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (sys_en),
        .tick  (tick)
    );

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = wr_en && (addr == ADDR_CTRL);
        cnt_wr   = wr_en && (addr == ADDR_CNT);
        stat_wr  = wr_en && (addr == ADDR_STAT);

        // The same edge qualifies an event and ends a gate of the opposite level.
        qual_edge = st_q.ctrl.pol ? pin_rise : pin_fall;
        gate_on   = pin_lvl ^ st_q.ctrl.pol;
        inc       = st_q.ctrl.en && sys_en &&
                    (st_q.ctrl.mode ? (tick && gate_on) : qual_edge);
        edge_set  = st_q.ctrl.en && qual_edge;
        ovf_set   = 1'b0;

        if (ctrl_wr) begin
            st_d.ctrl.en      = wdata[CB_EN];
            st_d.ctrl.mode    = wdata[CB_MODE];
            st_d.ctrl.pol     = wdata[CB_POL];
            st_d.ctrl.ovf_ie  = wdata[CB_OVF_IE];
            st_d.ctrl.edge_ie = wdata[CB_EDG_IE];
        end

        if (cnt_wr) begin
            st_d.cnt = wdata;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + DATA_W'(1);
            ovf_set  = &st_q.cnt;
        end

        if (stat_wr) begin
            if (wdata[SB_OVF]) st_d.ovf = 1'b0;
            if (wdata[SB_EDG]) st_d.edg = 1'b0;
        end
        if (ovf_set)  st_d.ovf = 1'b1;
        if (edge_set) st_d.edg = 1'b1;

        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[CB_EN]     = st_q.ctrl.en;
                rdata[CB_MODE]   = st_q.ctrl.mode;
                rdata[CB_POL]    = st_q.ctrl.pol;
                rdata[CB_OVF_IE] = st_q.ctrl.ovf_ie;
                rdata[CB_EDG_IE] = st_q.ctrl.edge_ie;
            end
            ADDR_CNT:  rdata = st_q.cnt;
            ADDR_STAT: begin
                rdata[SB_OVF] = st_q.ovf;
                rdata[SB_EDG] = st_q.edg;
            end
            default:   rdata = '0;
        endcase

        irq_ovf  = st_q.ovf & st_q.ctrl.ovf_ie;
        irq_edge = st_q.edg & st_q.ctrl.edge_ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] cnt,
    input logic         en,
    input logic         ovf
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == 2'd1);

    assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0) |-> (rdata[7] == 1'b0 && rdata[3] == 1'b0 && rdata[2] == 1'b0));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1)));

    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt));

    assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt == {W{1'b1}}) |=> (cnt != '0 || ovf));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && addr == 2'd2 && wdata[7])) |=> ovf);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));
endmodule

bind pulse_accum pa_checker #(.W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cnt   (st_q.cnt),
    .en    (st_q.ctrl.en),
    .ovf   (st_q.ovf)
);

// File: tb/sim_pulse_accum.sv
`timescale 1ns/1ps
module sim_pulse_accum;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b1;
    logic       pin_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_ovf, irq_edge;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pulse_accum u0 (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .pin_in(pin_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_ovf(irq_ovf), .irq_edge(irq_edge)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin_in = 1'b1;
            idle(2);
            pin_in = 1'b0;
            idle(2);
        end
        idle(4);
    endtask

    task automatic t_reset;
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 count");
        expect_reg(2'd2, 8'h00, "R1 status");
        check(!irq_ovf && !irq_edge, "R1 irq", {irq_ovf, irq_edge}, 0);
    endtask

    task automatic t_ctrl_layout;
        wr(2'd0, 8'hFF);
        expect_reg(2'd0, 8'h73, "R2 readback");
        expect_reg(2'd3, 8'h00, "R2 unused address");
        wr(2'd0, 8'h00);
    endtask

    task automatic t_event_rise;
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h00);
        pulses(3);
        expect_reg(2'd1, 8'd3, "R3 rising count");
        expect_reg(2'd2, 8'h40, "R7 edge flag event");
        wr(2'd2, 8'h00);
        expect_reg(2'd2, 8'h40, "R8 zero write keeps flag");
        wr(2'd2, 8'hC0);
        expect_reg(2'd2, 8'h00, "R8 clear");
    endtask

    task automatic t_event_fall;
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h00);
        pulses(4);
        expect_reg(2'd1, 8'd4, "R3 falling count");
    endtask

    task automatic t_fast_toggle;
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h00);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); pin_in = ~pin_in;
        end
        idle(5);
        expect_reg(2'd1, 8'd10, "R3 clk/2 rate");
    endtask

    task automatic t_gated_high;
        wr(2'd0, 8'h60);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hC0);
        @(negedge clk); pin_in = 1'b1;
        idle(320);
        pin_in = 1'b0;
        idle(5);
        expect_reg(2'd1, 8'd5, "R4 gate high 320 clocks");
        expect_reg(2'd2, 8'h40, "R7 gate trailing edge");
        idle(320);
        expect_reg(2'd1, 8'd5, "R4 inactive gate");
    endtask

    task automatic t_gated_low;
        wr(2'd0, 8'h70);
        @(negedge clk); pin_in = 1'b1;
        idle(5);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hC0);
        idle(192);
        expect_reg(2'd1, 8'd0, "R4 high is inactive");
        @(negedge clk); pin_in = 1'b0;
        idle(128);
        pin_in = 1'b1;
        idle(5);
        expect_reg(2'd1, 8'd2, "R4 gate low 128 clocks");
        expect_reg(2'd2, 8'h40, "R7 active-low trailing edge");
        @(negedge clk); pin_in = 1'b0;
        idle(5);
    endtask

    task automatic t_disabled;
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h20);
        wr(2'd2, 8'hC0);
        pulses(3);
        expect_reg(2'd1, 8'h20, "R5 no count");
        expect_reg(2'd2, 8'h00, "R5 no flags");
    endtask

    task automatic t_overflow;
        wr(2'd0, 8'h53);
        wr(2'd2, 8'hC0);
        wr(2'd1, 8'hFE);
        pulses(1);
        expect_reg(2'd2, 8'h40, "R6 no overflow at FF");
        check(irq_edge && !irq_ovf, "R9 edge request", {irq_ovf, irq_edge}, 1);
        pulses(1);
        expect_reg(2'd1, 8'h00, "R6 wrap");
        expect_reg(2'd2, 8'hC0, "R6 overflow flag");
        check(irq_ovf, "R9 overflow request", irq_ovf, 1);
        wr(2'd2, 8'h80);
        expect_reg(2'd2, 8'h40, "R8 clear overflow only");
        check(!irq_ovf && irq_edge, "R9 after clear", {irq_ovf, irq_edge}, 1);
        wr(2'd0, 8'h50);
        check(!irq_edge, "R9 masked", irq_edge, 0);
    endtask

    task automatic t_collision;
        wr(2'd0, 8'h50);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hC0);
        @(negedge clk); pin_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h33; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);
        expect_reg(2'd1, 8'h33, "R10 write wins");
        expect_reg(2'd2, 8'h40, "R10 no overflow");
        @(negedge clk); pin_in = 1'b0;
        idle(4);
    endtask

    task automatic t_sys_en;
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h00);
        @(negedge clk); sys_en = 1'b0;
        pulses(3);
        expect_reg(2'd1, 8'h00, "R11 frozen");
        @(negedge clk); sys_en = 1'b1;
        pulses(1);
        expect_reg(2'd1, 8'h01, "R11 resumes");
    endtask

    initial begin
        #100000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ctrl_layout();
        t_event_rise();
        t_event_fall();
        t_fast_toggle();
        t_gated_high();
        t_gated_low();
        t_disabled();
        t_overflow();
        t_collision();
        t_sys_en();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule